// File: doc/BRIEF.md
# Zero-latency serial fused multiply-add

This block evaluates either S = V·W + X + Y + Z or S = V·W + X·Y + Z on operands that arrive one bit per clock, least significant bit first. Bit t of S leaves the block in the same cycle as the operand bits of weight 2^t arrive. There is no register on the path from any operand input to the sum output. Callers that need V·W + X, V·W + X + Y or V·W + X·Y drive the unused operand inputs to zero.

The datapath is a chain of identical cells, one per result bit. Each cell captures the operand bits of its own index once, and from then on it forms the partial products that land on it in each following cycle. Each cell reduces those partial products and three carry bits with a seven-input ones counter. The three outputs of the counter are passed on to the cell below, kept in the same cell, or passed to the cell above, so that every cell keeps a fixed weight relative to the current output bit.

An operation starts when `start_i` is pulsed together with bit 0. The strobe discards everything the previous operation left behind, in the same cycle, so operations can run back to back. Unsigned operands are padded with zeros past bit OP_W-1. Two's-complement operands are padded by repeating their top bit. Either way, 2·OP_W+2 cycles give the full-precision result.

Top module: `bs_fused_mac`

## Requirements
- R1: `s_o` is a combinational function of the current inputs and of state stored at earlier edges. The output bit of weight 2^t is valid in the cycle t after the strobe, with no cycle of delay.
- R2: With `mode_i`=0, the 2·OP_W+2 output bits from the strobe cycle onward equal V·W+X+Y+Z mod 2^(2·OP_W+2) for unsigned OP_W-bit operands that are zero-padded.
- R3: With `mode_i`=1, the output bits equal V·W+X·Y+Z mod 2^(2·OP_W+2). `mode_i` changes only in a cycle where `start_i` is high.
- R4: Two's-complement operands padded by repeating their top bit produce the two's-complement result in both modes.
- R5: `start_i` high clears all stored operand bits and carries in its own cycle. This holds for a strobe right after a finished operation and for a strobe that cuts an operation short.
- R6: Driving unused inputs to zero gives V·W+X and V·W+X+Y in add mode, and V·W+X·Y in product mode.
- R7: After reset and before any strobe, no operand bit or carry is held. `s_o` is then 0 for all-zero inputs and equals `x_i` when only `x_i` is driven in add mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Marks bit 0 of a new operation and clears state |
| mode_i | input | 1 | 0: three addends, 1: second product X·Y plus Z |
| v_i | input | 1 | Serial operand V, LSB first |
| w_i | input | 1 | Serial operand W, LSB first |
| x_i | input | 1 | Serial operand X, LSB first |
| y_i | input | 1 | Serial operand Y, LSB first |
| z_i | input | 1 | Serial operand Z, LSB first |
| s_o | output | 1 | Serial result S, same cycle as the inputs |

## Verification
The clear of the previous operation's carries and the first output bit of the next operation fall in the same cycle. If the clear were one cycle late, stale carries would corrupt bit 0 or bit 1 of the new result. The bench provokes this case in two ways. It starts every operation directly after the last bit of the previous one, after sign-extended operands that leave many carries pending. It also strobes a new operation partway through an unfinished one. Each result is judged against integer arithmetic over all 2·OP_W+2 bits, and a separate check changes `z_i` within one cycle to confirm that `s_o` follows without an edge.

// File: rtl/bs_fused_mac_pkg.sv
package bs_fused_mac_pkg;
  typedef enum logic {
    MODE_ADD3  = 1'b0,
    MODE_PROD2 = 1'b1
  } mode_e;

  function automatic int res_width(input int op_w);
    return 2 * op_w + 2;
  endfunction
endpackage

// File: rtl/bs_fused_mac_cnt73.sv
module bs_fused_mac_cnt73 (
  input  logic [6:0] bits_i,
  output logic [2:0] cnt_o
);
  always_comb begin
    cnt_o = 3'd0;
    for (int i = 0; i < 7; i++) cnt_o = cnt_o + {2'b00, bits_i[i]};
  end
endmodule

// File: rtl/bs_fused_mac_seq.sv
module bs_fused_mac_seq #(
  parameter int CELLS = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic [CELLS-1:0] tok_o,
  output logic [CELLS-1:0] vld_o
);
  logic [CELLS-1:0] tok_q, vld_q;

  // strobe overrides history in the same cycle
  assign tok_o = start_i ? CELLS'(1) : tok_q;
  assign vld_o = start_i ? '0 : vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tok_q <= '0;
      vld_q <= '0;
    end else begin
      tok_q <= tok_o << 1;
      vld_q <= vld_o | tok_o;
    end
  end

  assert_tok_onehot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tok_q));
  assert_restart_tok_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (tok_q == CELLS'(2)));
  assert_restart_vld_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (vld_q == CELLS'(1)));
  assert_tok_ahead_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_q & vld_q) == '0);
endmodule

// File: rtl/bs_fused_mac_cell.sv
module bs_fused_mac_cell
  import bs_fused_mac_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  clr_i,
  input  logic  tok_i,
  input  logic  vld_i,
  input  mode_e mode_i,
  input  logic  v_i,
  input  logic  w_i,
  input  logic  x_i,
  input  logic  y_i,
  input  logic  ext_a_i,
  input  logic  ext_b_i,
  input  logic  ext_c_i,
  input  logic  lo_i,
  input  logic  hi_i,
  output logic  lo_o,
  output logic  hi_o
);
  logic       v_q, w_q, x_q, y_q;
  logic       lo_q, mid_q, hi_q;
  logic       lo_h, mid_h, hi_h;
  logic       v_s, x_s, w_e, y_e;
  logic [3:0] pp;
  logic [2:0] cnt;

  assign lo_h  = clr_i ? 1'b0 : lo_q;
  assign mid_h = clr_i ? 1'b0 : mid_q;
  assign hi_h  = clr_i ? 1'b0 : hi_q;

  // own-index bits: stored once captured, live in the capture cycle
  assign v_s = vld_i & v_q;
  assign x_s = vld_i & x_q;
  assign w_e = vld_i ? w_q : (tok_i & w_i);
  assign y_e = vld_i ? y_q : (tok_i & y_i);

  assign pp[0] = v_i & w_e;
  assign pp[1] = w_i & v_s;
  assign pp[2] = (mode_i == MODE_PROD2) ? (x_i & y_e) : ext_a_i;
  assign pp[3] = (mode_i == MODE_PROD2) ? (y_i & x_s) : ext_b_i;

  // hi_h is zero in cell 0, ext_c_i is zero elsewhere
  bs_fused_mac_cnt73 u_cnt (
    .bits_i({pp, lo_h, mid_h, hi_h | ext_c_i}),
    .cnt_o (cnt)
  );

  assign lo_o = cnt[0];
  assign hi_o = cnt[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q   <= 1'b0;
      w_q   <= 1'b0;
      x_q   <= 1'b0;
      y_q   <= 1'b0;
      lo_q  <= 1'b0;
      mid_q <= 1'b0;
      hi_q  <= 1'b0;
    end else begin
      if (tok_i) begin
        v_q <= v_i;
        w_q <= w_i;
        x_q <= x_i;
        y_q <= y_i;
      end
      lo_q  <= lo_i;
      mid_q <= cnt[1];
      hi_q  <= hi_i;
    end
  end

  assert_operand_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |=> ($stable(v_q) && $stable(w_q) && $stable(x_q) && $stable(y_q)));
  assert_capture_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_i |=> (v_q == $past(v_i) && w_q == $past(w_i)));
endmodule

// File: rtl/bs_fused_mac.sv
module bs_fused_mac
  import bs_fused_mac_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic mode_i,
  input  logic v_i,
  input  logic w_i,
  input  logic x_i,
  input  logic y_i,
  input  logic z_i,
  output logic s_o
);
  localparam int CELLS = res_width(OP_W);

  mode_e            mode;
  logic [CELLS-1:0] tok_w, vld_w;
  logic             lo_w [CELLS+1];
  logic             hi_w [CELLS+1];

  assign mode = mode_e'(mode_i);

  bs_fused_mac_seq #(.CELLS(CELLS)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .tok_o  (tok_w),
    .vld_o  (vld_w)
  );

  assign hi_w[0]     = 1'b0;
  assign lo_w[CELLS] = 1'b0;

  for (genvar k = 0; k < CELLS; k++) begin : g_cell
    bs_fused_mac_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (start_i),
      .tok_i  (tok_w[k]),
      .vld_i  (vld_w[k]),
      .mode_i (mode),
      .v_i    (v_i),
      .w_i    (w_i),
      .x_i    (x_i),
      .y_i    (y_i),
      .ext_a_i(k == 0 ? x_i : 1'b0),
      .ext_b_i(k == 0 ? y_i : 1'b0),
      .ext_c_i(k == 0 ? z_i : 1'b0),
      .lo_i   (lo_w[k+1]),
      .hi_i   (hi_w[k]),
      .lo_o   (lo_w[k]),
      .hi_o   (hi_w[k+1])
    );
  end

  assign s_o = lo_w[0];

  assert_mode_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |-> $stable(mode_i));
endmodule

// File: tb/bs_fused_mac_test.sv
module bs_fused_mac_test;
  localparam int N     = 4;
  localparam int CELLS = 2 * N + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, mode = 1'b0;
  logic v = 1'b0, w = 1'b0, x = 1'b0, y = 1'b0, z = 1'b0;
  logic s;
  int   checks = 0, errors = 0;

  always #2 clk = ~clk;

  bs_fused_mac #(.OP_W(N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .v_i(v), .w_i(w), .x_i(x), .y_i(y), .z_i(z), .s_o(s)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic ebit(input int val, input int t, input bit sgn);
    if (t < N) return val[t];
    return sgn ? val[N-1] : 1'b0;
  endfunction

  function automatic longint sx(input int val, input bit sgn);
    if (sgn && val[N-1]) return longint'(val) - (longint'(1) << N);
    return longint'(val);
  endfunction

  // cycles < CELLS aborts the operation without checking
  task automatic run_op(input bit md, input bit sgn, input int a, input int b,
                        input int c, input int d, input int e, input int cycles,
                        input string req);
    longint res = 0, exp;
    for (int t = 0; t < cycles; t++) begin
      @(negedge clk);
      start = (t == 0);
      if (t == 0) mode = md;
      v = ebit(a, t, sgn); w = ebit(b, t, sgn);
      x = ebit(c, t, sgn); y = ebit(d, t, sgn); z = ebit(e, t, sgn);
      #1;
      res = res | (longint'(s) << t);
    end
    if (cycles == CELLS) begin
      if (md) exp = sx(a, sgn) * sx(b, sgn) + sx(c, sgn) * sx(d, sgn) + sx(e, sgn);
      else    exp = sx(a, sgn) * sx(b, sgn) + sx(c, sgn) + sx(d, sgn) + sx(e, sgn);
      exp = exp & ((longint'(1) << CELLS) - 1);
      check(res == exp, req, res, exp);
    end
  endtask

  initial begin : watchdog
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #9 rst_n = 1'b1;
    // R7: no state before the first strobe
    repeat (3) @(negedge clk);
    #1 check(s == 1'b0, "R7", s, 0);
    x = 1'b1;
    #1 check(s == 1'b1, "R7", s, 1);
    @(negedge clk); x = 1'b0;
    #1 check(s == 1'b0, "R7", s, 0);

    // R1: output follows an input inside one cycle
    @(negedge clk); start = 1'b1; mode = 1'b0;
    #1 check(s == 1'b0, "R1", s, 0);
    z = 1'b1;
    #1 check(s == 1'b1, "R1", s, 1);

    // R2 R3 R4 plus R5 back-to-back: sweep V and W fully
    for (int md = 0; md < 2; md++)
      for (int sg = 0; sg < 2; sg++)
        for (int a = 0; a < 16; a++)
          for (int b = 0; b < 16; b++)
            run_op(md[0], sg[0], a, b, (a * 5 + 3) & 15, (b * 7 + a) & 15,
                   (a ^ (b << 1)) & 15, CELLS,
                   sg ? "R4 R5" : (md ? "R3 R5" : "R2 R5"));

    // R6: tied-off inputs
    run_op(1'b0, 1'b0, 15, 15, 15, 0, 0, CELLS, "R6");
    run_op(1'b0, 1'b1, 9, 13, 7, 8, 0, CELLS, "R6");
    run_op(1'b1, 1'b0, 15, 15, 15, 15, 0, CELLS, "R6");
    run_op(1'b1, 1'b1, 8, 8, 8, 8, 0, CELLS, "R6");

    // R5: strobe cutting an operation short
    for (int k = 1; k < CELLS; k++) begin
      run_op(1'b1, 1'b1, 15, 8, 9, 15, 15, k, "R5");
      run_op(1'b0, 1'b0, k, 15 - k, 3, 12, 15, CELLS, "R5");
      run_op(1'b1, 1'b1, 8, 8, 8, 8, 8, k, "R5");
      run_op(1'b1, 1'b0, 3, k, 15, 15, 1, CELLS, "R5");
    end

    @(negedge clk);
    start = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule